// File: doc/BRIEF.md
# Word Program Algorithm Sequencer

This block sits on the host side of a parallel NOR-style flash command bus and writes a run of consecutive words into the array. Software or an upstream engine gives it a first word address and a word count with a one-cycle `start`. The data words then arrive one at a time on a valid/ready stream. For every word the sequencer runs the full program-and-verify loop on the flash bus. That loop is a setup command write, an address-and-data write, a timed program pulse, a verify command write, a timed settle and a read-back compare. A word that reads back wrong is pulsed again, up to a fixed pulse budget. When the run is complete, or when a word uses up its budget, the sequencer writes the read-array command so the flash is left readable. It then reports completion with a one-cycle `done`, and the same cycle carries `err` if a word failed.

The data stream follows valid/ready rules. A word moves when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is raised only between words, while no bus cycle is in flight. At all other times it stays low, so the producer is back-pressured for the whole program/verify loop of the previous word. A producer that has raised `in_valid` keeps `in_data` unchanged until the transfer happens. The flash strobes are active low. Write-strobe low and high times, the read strobe time, and the program and verify waits are given in nanoseconds and converted to whole clock cycles, rounded up.

Top module: `wps_top`

## Requirements
- R1: While reset is held, and after it until `start`: `busy`, `done`, `err`, `in_ready` and `fl_dq_oe` are low, and `fl_we_n` and `fl_oe_n` are high.
- R2: `busy` is high from the cycle after `start` is taken until `done` rises. `done` is high for exactly one cycle, and `busy` is low in that cycle and afterwards.
- R3: `in_ready` is high only while the block waits for the next word, with both strobes high. One word is taken per handshake, and no word is taken beyond the current word count.
- R4: Each program pulse of a word is a write of 0x0040 followed by a write that carries the word address on `fl_addr` and the word on `fl_dq_out`.
- R5: From the rise of `fl_we_n` after the data write to the fall of `fl_we_n` for the 0x00C0 verify write, at least ceil(PGM_NS/CLK_NS) cycles pass. From the rise after 0x00C0 to the fall of `fl_oe_n`, at least ceil(VFY_NS/CLK_NS) cycles pass. The read-back is sampled when `fl_oe_n` has been low for ceil(READ_NS/CLK_NS) cycles.
- R6: A read-back equal to the word moves on to address+1 and the next stream word, so word i of a run lands at `start_addr`+i.
- R7: A read-back that differs repeats R4 and R5 with the same address and word. The pulse count is cleared for every word. A word that has not read back correctly after MAX_PULSES pulses stops the run as failed.
- R8: After the last word, or after a failure, the block writes 0x0000 and then raises `done`. `err` is high with `done` only when the run failed.
- R9: `fl_we_n` is low for exactly ceil(WE_LOW_NS/CLK_NS) cycles per write and high for at least ceil(WE_HIGH_NS/CLK_NS) cycles between writes. `fl_dq_oe` is high, and `fl_addr` and `fl_dq_out` are stable, for the whole low phase.
- R10: `fl_we_n` and `fl_oe_n` are never low together, and `fl_dq_oe` is low whenever `fl_oe_n` is low.
- R11: A `start` with a word count of 0 makes no program write. It writes 0x0000 only, then gives `done` without `err`.
- R12: A `start` while `busy` is high is ignored: the run in progress keeps its address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| start_addr | input | AW | Word address of the first word |
| word_count | input | AW+1 | Number of words in the run |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Block takes a word at this edge if valid |
| in_data | input | DW | Stream word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | With `done`: a word exhausted its pulse budget |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data driver |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_dq_in | input | DW | Data read from the flash |

## Verification
The bench drives a behavioural flash that needs a chosen number of pulses per address. It targets a word that needs exactly MAX_PULSES pulses and one that needs one more. An off-by-one in the pulse budget would fail the first or let the second pass. A failed word is placed in the middle of a run. A sequencer that kept going, fetched the next word, or skipped the closing 0x0000 write would leave a pulse count, a handshake count or the model's mode wrong. A zero-length run, a `start` issued mid-run, and random producer gaps check that the count is honoured and that the stream is never over-read. Strobe widths and the program and verify waits are measured in cycles against values the bench computes itself.

// File: rtl/wps_pkg.sv
package wps_pkg;

  // Low bytes of the flash command words; upper bits are zero.
  localparam logic [7:0] OP_READ_ARRAY = 8'h00;
  localparam logic [7:0] OP_PGM_SETUP  = 8'h40;
  localparam logic [7:0] OP_PGM_CHECK  = 8'hC0;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_SETUP,
    S_PROG,
    S_PWAIT,
    S_VCMD,
    S_VWAIT,
    S_READ,
    S_RESTORE,
    S_FINISH
  } seq_state_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/wps_timer.sv
module wps_timer #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] len,
  output logic          hit
);

  logic [LW-1:0] cnt_q;

  assign hit = run && (cnt_q == len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (run && !hit) cnt_q <= cnt_q + LW'(1);
    else                 cnt_q <= '0;
  end

endmodule

// File: rtl/wps_bus.sv
module wps_bus #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WL = 5,
  parameter int WH = 3,
  parameter int RD = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  input  logic [DW-1:0] fl_dq_in
);

  localparam int MAXC = (WL > WH) ? ((WL > RD) ? WL : RD) : ((WH > RD) ? WH : RD);
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {B_IDLE, B_WLOW, B_WHIGH, B_RLOW} bus_st_e;

  bus_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= B_IDLE;
      cnt_q     <= '0;
      ack       <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_we_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
    end else begin
      ack <= 1'b0;
      unique case (st_q)
        B_IDLE: begin
          // the ack cycle blocks a second start from a still-raised req
          if (req && !ack) begin
            fl_addr <= req_addr;
            if (req_rd) begin
              fl_oe_n <= 1'b0;
              cnt_q   <= CW'(RD - 1);
              st_q    <= B_RLOW;
            end else begin
              fl_dq_out <= req_data;
              fl_dq_oe  <= 1'b1;
              fl_we_n   <= 1'b0;
              cnt_q     <= CW'(WL - 1);
              st_q      <= B_WLOW;
            end
          end
        end
        B_WLOW: begin
          if (cnt_q == '0) begin
            fl_we_n <= 1'b1;
            cnt_q   <= CW'(WH - 1);
            st_q    <= B_WHIGH;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        B_WHIGH: begin
          if (cnt_q == '0) begin
            fl_dq_oe <= 1'b0;
            ack      <= 1'b1;
            st_q     <= B_IDLE;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        B_RLOW: begin
          if (cnt_q == '0) begin
            rdata   <= fl_dq_in;
            fl_oe_n <= 1'b1;
            ack     <= 1'b1;
            st_q    <= B_IDLE;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wps_top.sv
module wps_top
  import wps_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int CLK_NS     = 8,
  parameter int WE_LOW_NS  = 40,
  parameter int WE_HIGH_NS = 20,
  parameter int READ_NS    = 100,
  parameter int PGM_NS     = 10000,
  parameter int VFY_NS     = 6000,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW:0]   word_count,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  input  logic [DW-1:0] fl_dq_in
);

  localparam int WL_CYC  = ns_to_cyc(WE_LOW_NS, CLK_NS);
  localparam int WH_CYC  = ns_to_cyc(WE_HIGH_NS, CLK_NS);
  localparam int RD_CYC  = ns_to_cyc(READ_NS, CLK_NS);
  localparam int PGM_CYC = ns_to_cyc(PGM_NS, CLK_NS);
  localparam int VFY_CYC = ns_to_cyc(VFY_NS, CLK_NS);
  localparam int LW      = $clog2(((PGM_CYC > VFY_CYC) ? PGM_CYC : VFY_CYC) + 1);
  localparam int PW      = $clog2(MAX_PULSES + 1);

  seq_state_e     state_q;
  logic [AW-1:0]  addr_q;
  logic [AW:0]    left_q;
  logic [DW-1:0]  word_q;
  logic [PW-1:0]  pulses_q;
  logic           fail_q;

  logic           req, req_rd, ack;
  logic [DW-1:0]  req_data, rdata;
  logic           tmr_run, tmr_hit;
  logic [LW-1:0]  tmr_len;

  // bus request per state
  always_comb begin
    req      = 1'b0;
    req_rd   = 1'b0;
    req_data = word_q;
    unique case (state_q)
      S_SETUP:   begin req = 1'b1; req_data = DW'(OP_PGM_SETUP);  end
      S_PROG:    begin req = 1'b1; req_data = word_q;             end
      S_VCMD:    begin req = 1'b1; req_data = DW'(OP_PGM_CHECK);  end
      S_READ:    begin req = 1'b1; req_rd   = 1'b1;               end
      S_RESTORE: begin req = 1'b1; req_data = DW'(OP_READ_ARRAY); end
      default:   ;
    endcase
  end

  assign tmr_run = (state_q == S_PWAIT) || (state_q == S_VWAIT);
  assign tmr_len = (state_q == S_PWAIT) ? LW'(PGM_CYC) : LW'(VFY_CYC);

  assign in_ready = (state_q == S_FETCH);
  assign busy     = (state_q != S_IDLE) && (state_q != S_FINISH);
  assign done     = (state_q == S_FINISH);
  assign err      = done && fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      left_q   <= '0;
      word_q   <= '0;
      pulses_q <= '0;
      fail_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          addr_q  <= start_addr;
          left_q  <= word_count;
          fail_q  <= 1'b0;
          state_q <= (word_count == '0) ? S_RESTORE : S_FETCH;
        end
        S_FETCH: if (in_valid) begin
          word_q   <= in_data;
          pulses_q <= '0;
          state_q  <= S_SETUP;
        end
        S_SETUP: if (ack) state_q <= S_PROG;
        S_PROG:  if (ack) state_q <= S_PWAIT;
        S_PWAIT: if (tmr_hit) state_q <= S_VCMD;
        S_VCMD:  if (ack) state_q <= S_VWAIT;
        S_VWAIT: if (tmr_hit) state_q <= S_READ;
        S_READ: if (ack) begin
          if (rdata == word_q) begin
            if (left_q == (AW+1)'(1)) begin
              state_q <= S_RESTORE;
            end else begin
              addr_q  <= addr_q + AW'(1);
              left_q  <= left_q - (AW+1)'(1);
              state_q <= S_FETCH;
            end
          end else if (pulses_q == PW'(MAX_PULSES - 1)) begin
            fail_q  <= 1'b1;
            state_q <= S_RESTORE;
          end else begin
            pulses_q <= pulses_q + PW'(1);
            state_q  <= S_SETUP;
          end
        end
        S_RESTORE: if (ack) state_q <= S_FINISH;
        S_FINISH:  state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  wps_timer #(.LW(LW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tmr_run),
    .len   (tmr_len),
    .hit   (tmr_hit)
  );

  wps_bus #(
    .AW (AW),
    .DW (DW),
    .WL (WL_CYC),
    .WH (WH_CYC),
    .RD (RD_CYC)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_rd    (req_rd),
    .req_addr  (addr_q),
    .req_data  (req_data),
    .ack       (ack),
    .rdata     (rdata),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_dq_in  (fl_dq_in)
  );

endmodule

// File: rtl/wps_chk.sv
module wps_chk #(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int WL_CYC = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          in_ready,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out,
  input logic          fl_dq_oe,
  input logic          fl_we_n,
  input logic          fl_oe_n
);

  localparam int CW = $clog2(WL_CYC + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (!fl_we_n) low_cnt <= low_cnt + CW'(1);
    else              low_cnt <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (fl_we_n && fl_oe_n && !in_ready)); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && fl_we_n && fl_oe_n)); // R3
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R8
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (low_cnt == CW'(WL_CYC))); // R9
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_dq_oe); // R9
  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> (fl_we_n || ($stable(fl_addr) && $stable(fl_dq_out)))); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R10
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe); // R10

endmodule

bind wps_top wps_chk #(
  .AW     (AW),
  .DW     (DW),
  .WL_CYC (WL_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .in_ready  (in_ready),
  .fl_addr   (fl_addr),
  .fl_dq_out (fl_dq_out),
  .fl_dq_oe  (fl_dq_oe),
  .fl_we_n   (fl_we_n),
  .fl_oe_n   (fl_oe_n)
);

// File: tb/tb_wps_top.sv
`timescale 1ns/1ps
module tb_wps_top;

  localparam int AW = 8, DW = 16, CLK_NS = 8;
  localparam int WE_LOW_NS = 40, WE_HIGH_NS = 20, READ_NS = 100;
  localparam int PGM_NS = 800, VFY_NS = 480, MAXP = 25;
  localparam int NW = 1 << AW;
  localparam int M_READ = 0, M_SETUP = 1, M_PGM = 2, M_VFY = 3;

  function automatic int cyc_of(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW:0]   word_count = '0;
  logic [DW-1:0] in_data = '0, fl_dq_in;
  logic in_ready, busy, done, err, fl_dq_oe, fl_we_n, fl_oe_n;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;

  always #4 clk = ~clk;

  wps_top #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS), .WE_LOW_NS(WE_LOW_NS),
            .WE_HIGH_NS(WE_HIGH_NS), .READ_NS(READ_NS), .PGM_NS(PGM_NS),
            .VFY_NS(VFY_NS), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_dq_in(fl_dq_in));

  // behavioural flash model
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] expw [NW];
  int need [NW];
  int pulses [NW];
  int mode = M_READ, lat = 0, cyc = 0, fall_cyc = 0, rise_cyc = -100;
  int prog_rise = 0, vcmd_rise = 0, restore_cnt = 0, total_pulses = 0;
  int proto_bad = 0, wl_bad = 0, wh_bad = 0, pgm_bad = 0, vfy_bad = 0, ovl_bad = 0;
  int accepted = 0, total = 0, bad = 0;
  bit prev_we = 1'b1, prev_oe = 1'b1;

  always_comb fl_dq_in = (mode == M_VFY) ? mem[lat] : mem[int'(fl_addr)];

  always @(negedge clk) if (rst_n) begin
    cyc = cyc + 1;
    if (!fl_we_n && !fl_oe_n) ovl_bad++;
    if (!fl_we_n && prev_we) begin
      if (cyc - rise_cyc < cyc_of(WE_HIGH_NS)) wh_bad++;
      fall_cyc = cyc;
    end
    if (fl_we_n && !prev_we) begin
      if (cyc - fall_cyc != cyc_of(WE_LOW_NS)) wl_bad++;
      rise_cyc = cyc;
      if (mode == M_SETUP) begin
        lat = int'(fl_addr);
        pulses[lat]++; total_pulses++;
        if (fl_dq_out != expw[lat]) proto_bad++;
        if (pulses[lat] >= need[lat]) mem[lat] = fl_dq_out;
        prog_rise = cyc; mode = M_PGM;
      end else if (fl_dq_out == 16'h0040) begin
        mode = M_SETUP;
      end else if (fl_dq_out == 16'h00C0) begin
        if (mode != M_PGM) proto_bad++;
        if (fall_cyc - prog_rise < cyc_of(PGM_NS)) pgm_bad++;
        vcmd_rise = cyc; mode = M_VFY;
      end else if (fl_dq_out == 16'h0000) begin
        mode = M_READ; restore_cnt++;
      end else proto_bad++;
    end
    if (!fl_oe_n && prev_oe) begin
      if (mode != M_VFY) proto_bad++;
      if (cyc - vcmd_rise < cyc_of(VFY_NS)) vfy_bad++;
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  task automatic prep(input int base, input int n, input int nd);
    for (int i = 0; i < n; i++) begin
      expw[base+i] = DW'($urandom) & 16'hFFFE;
      mem[base+i] = 16'hFFFF;
      pulses[base+i] = 0;
      need[base+i] = (nd > 0) ? nd : 1 + ($urandom % 5);
    end
  endtask

  task automatic run_job(input int base, input int n, input int nfeed,
                         input int gapmax, input bit poke, output bit got_err);
    int k;
    accepted = 0;
    @(negedge clk);
    start = 1'b1; start_addr = AW'(base); word_count = (AW+1)'(n);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    fork
      begin
        for (int i = 0; i < nfeed; i++) begin
          repeat ($urandom % (gapmax + 1)) @(negedge clk);
          in_valid = 1'b1; in_data = expw[base+i];
          while (!in_ready) @(negedge clk);
          @(negedge clk);
          in_valid = 1'b0; accepted++;
        end
      end
      begin
        k = 0;
        while (!done) begin
          @(negedge clk); k++;
          if (poke && k == 50) begin
            start = 1'b1; start_addr = 8'h70; word_count = 9'd5;
            @(negedge clk); start = 1'b0;
          end
        end
      end
    join
    got_err = err;
    @(negedge clk);
    chk(!done && !busy, "R2", "done single cycle then idle", int'(done) + int'(busy), 0);
    chk(accepted == nfeed && !in_ready, "R3", "words taken", accepted, nfeed);
  endtask

  task automatic bus_checks(input int tag);
    chk(proto_bad == 0, "R4", $sformatf("command order job%0d", tag), proto_bad, 0);
    chk(pgm_bad == 0 && vfy_bad == 0, "R5", $sformatf("waits job%0d", tag), pgm_bad + vfy_bad, 0);
    chk(wl_bad == 0 && wh_bad == 0, "R9", $sformatf("strobe widths job%0d", tag), wl_bad + wh_bad, 0);
    chk(ovl_bad == 0, "R10", $sformatf("strobe overlap job%0d", tag), ovl_bad, 0);
  endtask

  task automatic word_checks(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      chk(mem[base+i] == expw[base+i], "R6", $sformatf("word at %0d", base+i),
          int'(mem[base+i]), int'(expw[base+i]));
      chk(pulses[base+i] == need[base+i], "R7", $sformatf("pulses at %0d", base+i),
          pulses[base+i], need[base+i]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit e;
    int r0, p0, b, n;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin
      mem[i] = 16'hFFFF; expw[i] = '0; need[i] = 1; pulses[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !in_ready && fl_we_n && fl_oe_n && !fl_dq_oe,
        "R1", "in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !in_ready && fl_we_n && fl_oe_n && !fl_dq_oe, "R1", "after reset",
        int'(busy) + int'(in_ready), 0);

    // random runs with producer gaps
    for (int j = 0; j < 3; j++) begin
      b = 16 + 32 * j + ($urandom % 8); n = 1 + ($urandom % 5);
      prep(b, n, 0);
      r0 = restore_cnt;
      run_job(b, n, n, 12, 1'b0, e);
      chk(e == 1'b0, "R8", "random run no err", int'(e), 0);
      chk(restore_cnt == r0 + 1 && mode == M_READ, "R8", "read mode restored",
          restore_cnt - r0, 1);
      word_checks(b, n);
      bus_checks(j);
    end

    // exactly MAX pulses still passes
    prep(8'hA0, 1, MAXP);
    run_job(8'hA0, 1, 1, 0, 1'b0, e);
    chk(e == 1'b0, "R7", "word needing max pulses passes", int'(e), 0);
    word_checks(8'hA0, 1);

    // one more than max fails mid-run and stops
    prep(8'hB0, 3, 1);
    need[8'hB1] = MAXP + 1;
    r0 = restore_cnt;
    run_job(8'hB0, 3, 2, 3, 1'b0, e);
    chk(e == 1'b1, "R8", "err with done on failure", int'(e), 1);
    chk(pulses[8'hB1] == MAXP, "R7", "pulse budget on failure", pulses[8'hB1], MAXP);
    chk(pulses[8'hB2] == 0, "R7", "no word after failure", pulses[8'hB2], 0);
    chk(restore_cnt == r0 + 1 && mode == M_READ, "R8", "restore after failure",
        restore_cnt - r0, 1);
    bus_checks(10);

    // zero count
    p0 = total_pulses; r0 = restore_cnt;
    run_job(8'hC0, 0, 0, 0, 1'b0, e);
    chk(total_pulses == p0, "R11", "no program write", total_pulses - p0, 0);
    chk(restore_cnt == r0 + 1 && e == 1'b0, "R11", "only read-mode write",
        restore_cnt - r0, 1);

    // start while busy is ignored
    prep(8'h60, 2, 2);
    prep(8'h70, 5, 1);
    run_job(8'h60, 2, 2, 0, 1'b1, e);
    chk(pulses[8'h70] == 0 && e == 1'b0, "R12", "second start ignored", pulses[8'h70], 0);
    word_checks(8'h60, 2);
    bus_checks(20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule